// File: doc/BRIEF.md
# Spatial-Temporal Region Compactor

This block sits on the stream of retired instruction addresses feeding an instruction prefetcher. It compresses that stream into region records. Each address is reduced to a cache-block number by dropping the offset bits. One record is open at a time. It is anchored on a trigger block and carries two small bit vectors. One vector marks blocks touched just below the trigger and the other marks blocks touched just above it.

When a retired block lands outside the open region, the record is closed and a new one opens on that block with all bits clear. A closed record goes to a small recency list holding the last few distinct records. If the record is already in the list, that entry is promoted to most recent and nothing is emitted. Otherwise the record is inserted, the oldest entry is dropped if the list is full, and the record is presented on a valid/ready output. While that output is stalled, the retire input is held off so that no record is lost.

A combinational query port reports whether an address is covered by the open record. The consumer can rebuild the predicted block set of an emitted record as the trigger block plus one block for each set bit.

Top module: `rc_compactor`

## Requirements
- R1: With trigger block T, a retired block B with 1 <= B-T <= SUCC sets bit (B-T-1) of the succeeding vector, and a block with 1 <= T-B <= PREC sets bit (T-B-1) of the preceding vector. Block numbers are the address shifted right by BLK_LOG, and the arithmetic is modulo the block-number width.
- R2: A retired address in the trigger block itself leaves the open record unchanged.
- R3: A retired block outside the open region closes the record. A new record opens with that block as trigger and both vectors zero. An emitted record appears as out_trig (trigger block number), out_prec and out_succ.
- R4: qry_hit is 1 when the query block is the open trigger, or lies in range with its bit set. It is 0 otherwise, and 0 whenever no record is open.
- R5: After reset out_valid=0, ret_ready=1 and qry_hit=0. The first accepted retire opens a record without emitting.
- R6: A closed record equal in trigger and both vectors to an entry held in the recency list is not emitted, and that entry becomes most recent.
- R7: A closed record not in the list is emitted and inserted as most recent. When DEPTH entries are held, the least recent one is dropped, so a later recurrence of it is emitted again.
- R8: While out_valid=1 and out_ready=0, ret_ready=0, the output fields stay stable, and the open record is not changed. The pending record and the next one are both delivered once the output is ready.
- R9: out_valid rises only in the cycle after an accepted retire that closed a new record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Retired address present |
| ret_ready | output | 1 | Retired address can be taken |
| ret_addr | input | ADDR_W | Retired instruction address |
| out_valid | output | 1 | Emitted record present |
| out_ready | input | 1 | Consumer takes the record |
| out_trig | output | ADDR_W-BLK_LOG | Trigger block number of the record |
| out_prec | output | PREC | Blocks below the trigger that were touched |
| out_succ | output | SUCC | Blocks above the trigger that were touched |
| qry_addr | input | ADDR_W | Coverage query address |
| qry_hit | output | 1 | Query address is covered by the open record |

## Verification
A retire is accepted at a rising edge. The open record changes at that edge, so a query driven afterwards shows the new state combinationally. An emitted record is on the output from the same edge, so the scoreboard monitor reads it at the following falling edge. The driver pushes each expected record before it issues the retire that closes it. The monitor pops one entry at each falling edge where out_valid and out_ready are both high, and every query is sampled a nanosecond after its address is driven at a falling edge. The change of out_ready is made just after a rising edge, so no handshake is decided in the same instant it is sampled.

// File: rtl/rc_pkg.sv
package rc_pkg;
   // Position of a block relative to a region trigger
   typedef enum logic [1:0] {
      REL_TRIG = 2'd0,
      REL_PREC = 2'd1,
      REL_SUCC = 2'd2,
      REL_OUT  = 2'd3
   } rel_e;
endpackage

// File: rtl/rc_locate.sv
// Classifies a probe block against a trigger block and gives the bit index.
module rc_locate
   import rc_pkg::*;
#(
   parameter int BW   = 26,
   parameter int PREC = 4,
   parameter int SUCC = 8,
   parameter int IW   = 4
) (
   input  logic [BW-1:0] base_blk,
   input  logic [BW-1:0] probe_blk,
   output rel_e          rel,
   output logic [IW-1:0] idx
);
   logic [BW-1:0] up_dist;
   logic [BW-1:0] dn_dist;

   always_comb begin
      up_dist = probe_blk - base_blk;
      dn_dist = base_blk - probe_blk;
      rel     = REL_OUT;
      idx     = '0;
      if (probe_blk == base_blk) begin
         rel = REL_TRIG;
      end else if (up_dist <= BW'(SUCC)) begin
         rel = REL_SUCC;
         idx = IW'(up_dist - BW'(1));
      end else if (dn_dist <= BW'(PREC)) begin
         rel = REL_PREC;
         idx = IW'(dn_dist - BW'(1));
      end
   end
endmodule

// File: rtl/rc_spatial.sv
// Holds the open region record and answers coverage queries.
module rc_spatial
   import rc_pkg::*;
#(
   parameter int BW   = 26,
   parameter int PREC = 4,
   parameter int SUCC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc,
   input  logic [BW-1:0]   ret_blk,
   input  logic [BW-1:0]   qry_blk,
   output logic            open_vld,
   output logic [BW-1:0]   cur_trig,
   output logic [PREC-1:0] cur_prec,
   output logic [SUCC-1:0] cur_succ,
   output logic            close,
   output logic            qry_hit
);
   localparam int MAXW = (PREC > SUCC) ? PREC : SUCC;
   localparam int IW   = $clog2(MAXW + 1);

   rel_e          rel_r, rel_q;
   logic [IW-1:0] idx_r, idx_q;

   rc_locate #(.BW(BW), .PREC(PREC), .SUCC(SUCC), .IW(IW)) u_loc_ret (
      .base_blk (cur_trig),
      .probe_blk(ret_blk),
      .rel      (rel_r),
      .idx      (idx_r)
   );

   rc_locate #(.BW(BW), .PREC(PREC), .SUCC(SUCC), .IW(IW)) u_loc_qry (
      .base_blk (cur_trig),
      .probe_blk(qry_blk),
      .rel      (rel_q),
      .idx      (idx_q)
   );

   assign close = acc && open_vld && (rel_r == REL_OUT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_vld <= 1'b0;
         cur_trig <= '0;
         cur_prec <= '0;
         cur_succ <= '0;
      end else if (acc) begin
         if (!open_vld || rel_r == REL_OUT) begin
            open_vld <= 1'b1;
            cur_trig <= ret_blk;
            cur_prec <= '0;
            cur_succ <= '0;
         end else begin
            unique case (rel_r)
               REL_PREC: begin
                  for (int i = 0; i < PREC; i++)
                     if (idx_r == IW'(i)) cur_prec[i] <= 1'b1;
               end
               REL_SUCC: begin
                  for (int i = 0; i < SUCC; i++)
                     if (idx_r == IW'(i)) cur_succ[i] <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      qry_hit = 1'b0;
      unique case (rel_q)
         REL_TRIG: qry_hit = open_vld;
         REL_PREC: begin
            for (int i = 0; i < PREC; i++)
               if (idx_q == IW'(i)) qry_hit = open_vld & cur_prec[i];
         end
         REL_SUCC: begin
            for (int i = 0; i < SUCC; i++)
               if (idx_q == IW'(i)) qry_hit = open_vld & cur_succ[i];
         end
         default: qry_hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/rc_recent.sv
// Recency list of closed records; entry 0 is the most recent.
module rc_recent #(
   parameter int BW    = 26,
   parameter int PREC  = 4,
   parameter int SUCC  = 8,
   parameter int DEPTH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ins,
   input  logic [BW-1:0]   in_trig,
   input  logic [PREC-1:0] in_prec,
   input  logic [SUCC-1:0] in_succ,
   output logic            is_new
);
   logic [DEPTH-1:0] match;
   logic [DEPTH-1:0] shift;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         shift[i] = ~|match;
         for (int j = i; j < DEPTH; j++)
            if (match[j]) shift[i] = 1'b1;
      end
   end

   assign is_new = ~|match;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic            vld;
      logic [BW-1:0]   trig;
      logic [PREC-1:0] prec;
      logic [SUCC-1:0] succ;

      assign match[g] = vld && (trig == in_trig) && (prec == in_prec) && (succ == in_succ);

      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld  <= 1'b0;
               trig <= '0;
               prec <= '0;
               succ <= '0;
            end else if (ins) begin
               vld  <= 1'b1;
               trig <= in_trig;
               prec <= in_prec;
               succ <= in_succ;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld  <= 1'b0;
               trig <= '0;
               prec <= '0;
               succ <= '0;
            end else if (ins && shift[g]) begin
               vld  <= g_ent[g-1].vld;
               trig <= g_ent[g-1].trig;
               prec <= g_ent[g-1].prec;
               succ <= g_ent[g-1].succ;
            end
         end
      end
   end
endmodule

// File: rtl/rc_compactor.sv
module rc_compactor #(
   parameter int ADDR_W  = 32,
   parameter int BLK_LOG = 6,
   parameter int PREC    = 4,
   parameter int SUCC    = 8,
   parameter int DEPTH   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ret_valid,
   output logic                      ret_ready,
   input  logic [ADDR_W-1:0]         ret_addr,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [ADDR_W-BLK_LOG-1:0] out_trig,
   output logic [PREC-1:0]           out_prec,
   output logic [SUCC-1:0]           out_succ,
   input  logic [ADDR_W-1:0]         qry_addr,
   output logic                      qry_hit
);
   localparam int BW = ADDR_W - BLK_LOG;

   if (BLK_LOG < 0 || BLK_LOG >= ADDR_W) begin : g_bad_blk
      $error("rc_compactor: BLK_LOG must lie in [0, ADDR_W)");
   end
   if (PREC < 1 || SUCC < 1) begin : g_bad_vec
      $error("rc_compactor: PREC and SUCC must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("rc_compactor: DEPTH must be at least 1");
   end

   logic [BW-1:0]   ret_blk, qry_blk;
   logic            acc, close, is_new, emit, open_vld;
   logic [BW-1:0]   cur_trig;
   logic [PREC-1:0] cur_prec;
   logic [SUCC-1:0] cur_succ;

   assign ret_blk   = BW'(ret_addr >> BLK_LOG);
   assign qry_blk   = BW'(qry_addr >> BLK_LOG);
   assign ret_ready = !out_valid || out_ready;
   assign acc       = ret_valid && ret_ready;
   assign emit      = close && is_new;

   rc_spatial #(.BW(BW), .PREC(PREC), .SUCC(SUCC)) u_spatial (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .ret_blk (ret_blk),
      .qry_blk (qry_blk),
      .open_vld(open_vld),
      .cur_trig(cur_trig),
      .cur_prec(cur_prec),
      .cur_succ(cur_succ),
      .close   (close),
      .qry_hit (qry_hit)
   );

   rc_recent #(.BW(BW), .PREC(PREC), .SUCC(SUCC), .DEPTH(DEPTH)) u_recent (
      .clk    (clk),
      .rst_n  (rst_n),
      .ins    (close),
      .in_trig(cur_trig),
      .in_prec(cur_prec),
      .in_succ(cur_succ),
      .is_new (is_new)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_trig  <= '0;
         out_prec  <= '0;
         out_succ  <= '0;
      end else if (emit) begin
         out_valid <= 1'b1;
         out_trig  <= cur_trig;
         out_prec  <= cur_prec;
         out_succ  <= cur_succ;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/rc_compactor_chk.sv
module rc_compactor_chk #(
   parameter int BW   = 26,
   parameter int PREC = 4,
   parameter int SUCC = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ret_ready,
   input logic            acc,
   input logic            open_vld,
   input logic            out_valid,
   input logic            out_ready,
   input logic [BW-1:0]   out_trig,
   input logic [PREC-1:0] out_prec,
   input logic [SUCC-1:0] out_succ,
   input logic            qry_hit
);
   assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !ret_ready);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_trig)
                                     && $stable(out_prec) && $stable(out_succ)));

   assert_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(acc));

   assert_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !open_vld) |=> !out_valid);

   assert_query_R4: assert property (@(posedge clk) disable iff (!rst_n)
      qry_hit |-> open_vld);
endmodule

bind rc_compactor rc_compactor_chk #(
   .BW  (ADDR_W - BLK_LOG),
   .PREC(PREC),
   .SUCC(SUCC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ret_ready(ret_ready),
   .acc      (acc),
   .open_vld (open_vld),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_trig (out_trig),
   .out_prec (out_prec),
   .out_succ (out_succ),
   .qry_hit  (qry_hit)
);

// File: tb/rc_compactor_bench.sv
`timescale 1ns/1ps
module rc_compactor_bench;
   localparam int ADDR_W  = 32;
   localparam int BLK_LOG = 6;
   localparam int PREC    = 4;
   localparam int SUCC    = 8;
   localparam int DEPTH   = 4;
   localparam int BW      = ADDR_W - BLK_LOG;

   typedef struct packed {
      logic [BW-1:0]   trig;
      logic [PREC-1:0] prec;
      logic [SUCC-1:0] succ;
   } rec_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ret_valid = 1'b0;
   logic              ret_ready;
   logic [ADDR_W-1:0] ret_addr = '0;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic [BW-1:0]     out_trig;
   logic [PREC-1:0]   out_prec;
   logic [SUCC-1:0]   out_succ;
   logic [ADDR_W-1:0] qry_addr = '0;
   logic              qry_hit;

   int    n_chk = 0;
   int    n_bad = 0;
   rec_t  exp_q[$];
   string tag_q[$];
   bit    bp_done = 1'b0;

   always #2.5 clk = ~clk;

   rc_compactor #(.ADDR_W(ADDR_W), .BLK_LOG(BLK_LOG), .PREC(PREC),
                  .SUCC(SUCC), .DEPTH(DEPTH)) u_rc_compactor (
      .clk      (clk),
      .rst_n    (rst_n),
      .ret_valid(ret_valid),
      .ret_ready(ret_ready),
      .ret_addr (ret_addr),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_trig (out_trig),
      .out_prec (out_prec),
      .out_succ (out_succ),
      .qry_addr (qry_addr),
      .qry_hit  (qry_hit)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // Driver side: record what must come out before causing it
   task automatic expect_rec(input int trig, input int prec, input int succ, input string tag);
      rec_t r;
      r.trig = BW'(trig);
      r.prec = PREC'(prec);
      r.succ = SUCC'(succ);
      exp_q.push_back(r);
      tag_q.push_back(tag);
   endtask

   // Called at a falling edge; returns at the falling edge after acceptance
   task automatic retire(input int blk);
      ret_addr  = ADDR_W'(blk) << BLK_LOG;
      ret_valid = 1'b1;
      forever begin
         bit ok;
         ok = ret_ready;
         @(posedge clk);
         if (ok) break;
         @(negedge clk);
      end
      @(negedge clk);
      ret_valid = 1'b0;
   endtask

   task automatic query(input int blk, input bit exp, input string tag);
      qry_addr = (ADDR_W'(blk) << BLK_LOG) | ADDR_W'(blk % 64);
      #1;
      check(qry_hit == exp, tag, 64'(qry_hit), 64'(exp));
   endtask

   // Monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() > 0) begin
            rec_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({out_trig, out_prec, out_succ} == e, t,
                  64'({out_trig, out_prec, out_succ}), 64'(e));
         end else begin
            check(1'b0, "R6 unexpected emission", 64'(out_trig), 64'(0));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 64'(0), 64'(1));
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: reset state
      check(out_valid == 1'b0, "R5 out_valid after reset", 64'(out_valid), 64'(0));
      check(ret_ready == 1'b1, "R5 ret_ready after reset", 64'(ret_ready), 64'(1));
      query(100, 1'b0, "R5 no open record");

      // R5: first retire opens without emitting
      retire(100);
      check(out_valid == 1'b0, "R5 first retire emits nothing", 64'(out_valid), 64'(0));
      query(100, 1'b1, "R4 trigger block covered");
      query(101, 1'b0, "R4 clear bit not covered");

      // R1: fill bits at both range edges; R2: trigger block again
      retire(101);
      retire(103);
      retire(108);
      retire(96);
      retire(100);
      query(101, 1'b1, "R1 succ bit 0");
      query(102, 1'b0, "R4 untouched block");
      query(108, 1'b1, "R1 succ edge bit");
      query(96, 1'b1, "R1 prec edge bit");
      query(95, 1'b0, "R1 below prec range");
      query(109, 1'b0, "R1 above succ range");

      // R3: close record A (also checks R2: content unchanged by the repeat)
      expect_rec(100, 4'b1000, 8'b1000_0101, "R3 record A");
      retire(109);
      check(out_valid == 1'b1, "R9 emission next cycle", 64'(out_valid), 64'(1));
      query(109, 1'b1, "R3 new trigger");
      query(110, 1'b0, "R3 new record clear");

      expect_rec(109, 0, 0, "R3 record B");
      retire(104);
      expect_rec(104, 0, 0, "R3 record C");
      retire(500);
      expect_rec(500, 0, 0, "R7 record D");
      retire(100);
      retire(101);
      retire(103);
      retire(108);
      retire(96);
      // R6: A, B, C repeat and are suppressed, each promoted
      retire(109);
      retire(104);
      retire(700);
      // R7: new records push out D then A
      expect_rec(700, 0, 0, "R7 record E");
      retire(900);
      expect_rec(900, 0, 0, "R7 record F");
      retire(500);
      expect_rec(500, 0, 0, "R7 evicted D emitted again");
      retire(100);
      expect_rec(100, 0, 0, "R6 bits differ from A");
      retire(109);

      // R8: back-pressure
      @(posedge clk);
      #1 out_ready = 1'b0;
      @(negedge clk);
      expect_rec(109, 0, 0, "R8 pending record H");
      retire(2000);
      expect_rec(2000, 0, 0, "R8 record after stall");
      fork
         begin
            retire(3000);
            bp_done = 1'b1;
         end
      join_none
      repeat (3) @(negedge clk);
      check(ret_ready == 1'b0, "R8 ret_ready low", 64'(ret_ready), 64'(0));
      check(out_valid == 1'b1 && out_trig == BW'(109), "R8 record held",
            64'(out_trig), 64'(109));
      query(2000, 1'b1, "R8 open record untouched");
      @(posedge clk);
      #1 out_ready = 1'b1;
      wait (bp_done);
      query(3000, 1'b1, "R3 trigger after stall");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R7 all expected records seen", 64'(exp_q.size()), 64'(0));
      finish_run();
   end
endmodule